// File: doc/BRIEF.md
# DRAM Strobe Sequencer with Open-Row Tracking and Refresh

This block sits between a simple host request port and a classical asynchronous DRAM. Each host request carries a flat word address, a write flag and write data. The controller splits the address into a row half (upper bits) and a column half (lower bits). It puts both halves on one shared set of address pins, row first and column second, and it generates the row strobe, column strobe and write-enable sequences in whole clock counts.

After an access the row strobe stays asserted, so the row stays open. A later request to the same row therefore needs only a new column strobe cycle. A request to a different row first closes the open row, waits out the precharge time, and then opens the new row. A free-running interval timer raises a refresh request. When that request is pending, new host requests are held off, any open row is closed, and one refresh runs. The refresh style is chosen by an input pin: either a row-strobe-only cycle driven from an internal row counter, or a column-before-row cycle that relies on the DRAM's own counter.

Top module: `dramc_ctrl`

## Requirements
- R1: The address pins carry the row half (`req_addr[ADDR_W-1:COL_W]`) while the row strobe falls. They carry the column half (`req_addr[COL_W-1:0]`) while the column strobe is low. The column strobe falls no earlier than T_RCD cycles after the row strobe falls.
- R2: On a write (`req_we`=1), `dram_we_n` is 0 and `dram_dq_oe` is 1 with the write data on `dram_dq_out`, only while both strobes are low. The column strobe of every host access stays low for exactly T_CAS cycles.
- R3: On a read, `dram_dq_in` is captured in the last cycle of the column pulse. It is returned on `rsp_rdata`, with `rsp_valid` high for one cycle, in the next cycle. Writes produce no response.
- R4: A request whose row equals the open row keeps the row strobe low and cycles only the column strobe.
- R5: A request to a different row raises the row strobe, holds it high for at least T_RP cycles, and then opens the new row.
- R6: A refresh request is raised every REF_INTERVAL cycles. While it is pending, `req_ready` is 0. When the controller is idle with no row open, refreshes start exactly REF_INTERVAL cycles apart.
- R7: With `ref_mode`=0, a refresh is a row-strobe cycle with the column strobe held high. The address pins carry an internal row counter, which starts at 0 after reset and advances by one (wrapping) after each such refresh.
- R8: With `ref_mode`=1, the column strobe falls at least one cycle before the row strobe and stays low until the row strobe rises. The internal row counter does not advance.
- R9: A pending refresh closes an open row, then waits at least T_RP cycles before the refresh row strobe falls.
- R10: After synchronous reset, both strobes are high, no row is open, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted this cycle when valid |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DATA_W | Read data |
| ref_mode | input | 1 | 0 = row-strobe-only refresh, 1 = column-before-row refresh |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_dq_out | output | DATA_W | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | DATA_W | Data returned by the DRAM |

## Verification
The bench runs every address of a small array through sequential sweeps, which hit the open page, and stride-9 sweeps, which miss a row on every access. A controller that drops page mode shows one row opening per access instead of one per row. A controller that latches the wrong address half corrupts the read-back data. The bench DRAM model measures each precharge gap, row-to-column delay and column pulse width, so a shortened timer shows up as a too-short interval. Idle windows in each refresh style expose a row counter that skips or does not advance, a refresh that fires in the wrong style, and a timer whose spacing is off by a cycle.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_CAS,
        ST_PRE,
        ST_RREF,
        ST_CBR_LEAD,
        ST_CBR_HOLD
    } dram_state_e;

    typedef enum logic [1:0] {
        AFTER_IDLE,
        AFTER_ACT,
        AFTER_REF
    } pre_next_e;

    localparam logic REF_STYLE_RAS_ONLY = 1'b0;
    localparam logic REF_STYLE_CBR      = 1'b1;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dramc_ref_timer.sv
module dramc_ref_timer #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pending <= 1'b0;
        end else begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            if (wrap)
                pending <= 1'b1;
            else if (ack)
                pending <= 1'b0;
        end
    end

    // R6: a raised refresh request is held until it is taken
    assert_pending_held_R6: assert property (@(posedge clk) disable iff (rst)
        (pending && !ack) |=> pending);

endmodule

// File: rtl/dramc_row_track.sv
module dramc_row_track #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_en,
    input  logic [ROW_W-1:0] open_row,
    input  logic             close,
    input  logic [ROW_W-1:0] probe_row,
    output logic             row_open,
    output logic             hit
);
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_open <= 1'b0;
            row_q    <= '0;
        end else if (close) begin
            row_open <= 1'b0;
        end else if (open_en) begin
            row_open <= 1'b1;
            row_q    <= open_row;
        end
    end

    assign hit = row_open && (row_q == probe_row);

    // R5: closing a row leaves nothing open in the next cycle
    assert_close_clears_R5: assert property (@(posedge clk) disable iff (rst)
        close |=> !row_open);

endmodule

// File: rtl/dramc_ctrl.sv
module dramc_ctrl
    import dramc_pkg::*;
#(
    parameter int ROW_W        = 10,
    parameter int COL_W        = 10,
    parameter int DATA_W       = 16,
    parameter int T_RCD        = 3,
    parameter int T_CAS        = 2,
    parameter int T_RP         = 3,
    parameter int REF_INTERVAL = 1560
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                req_valid,
    output logic                                req_ready,
    input  logic [ROW_W+COL_W-1:0]              req_addr,
    input  logic                                req_we,
    input  logic [DATA_W-1:0]                   req_wdata,
    output logic                                rsp_valid,
    output logic [DATA_W-1:0]                   rsp_rdata,
    input  logic                                ref_mode,
    output logic                                dram_ras_n,
    output logic                                dram_cas_n,
    output logic                                dram_we_n,
    output logic [imax(ROW_W, COL_W)-1:0]       dram_addr,
    output logic [DATA_W-1:0]                   dram_dq_out,
    output logic                                dram_dq_oe,
    input  logic [DATA_W-1:0]                   dram_dq_in
);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int PIN_W  = imax(ROW_W, COL_W);
    localparam int T_RAS  = T_RCD + T_CAS;
    localparam int CNT_W  = $clog2(imax(imax(T_RCD, T_CAS), imax(T_RP, T_RAS)) + 1);

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              we;
        logic [DATA_W-1:0] wdata;
    } host_req_t;

    dram_state_e      st_q, st_d;
    pre_next_e        after_q, after_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    host_req_t        req_q;
    logic [ROW_W-1:0] ref_row_q;
    logic [ROW_W-1:0] in_row;
    logic             ref_pend, ref_ack;
    logic             open_en, close_row, row_open, row_hit;
    logic             accept, ref_row_inc, cap_rd;

    assign in_row = req_addr[ADDR_W-1:COL_W];

    dramc_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .ack     (ref_ack),
        .pending (ref_pend)
    );

    dramc_row_track #(.ROW_W(ROW_W)) u_rows (
        .clk       (clk),
        .rst       (rst),
        .open_en   (open_en),
        .open_row  (accept ? in_row : req_q.row),
        .close     (close_row),
        .probe_row (in_row),
        .row_open  (row_open),
        .hit       (row_hit)
    );

    assign req_ready = (st_q == ST_IDLE) && !ref_pend;

    always_comb begin
        st_d        = st_q;
        after_d     = after_q;
        cnt_d       = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
        ref_ack     = 1'b0;
        open_en     = 1'b0;
        close_row   = 1'b0;
        accept      = 1'b0;
        ref_row_inc = 1'b0;
        cap_rd      = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (ref_pend) begin
                    if (row_open) begin
                        st_d      = ST_PRE;
                        cnt_d     = CNT_W'(T_RP - 1);
                        after_d   = AFTER_REF;
                        close_row = 1'b1;
                    end else begin
                        ref_ack = 1'b1;
                        st_d    = (ref_mode == REF_STYLE_CBR) ? ST_CBR_LEAD : ST_RREF;
                        cnt_d   = (ref_mode == REF_STYLE_CBR) ? '0 : CNT_W'(T_RAS - 1);
                    end
                end else if (req_valid) begin
                    accept = 1'b1;
                    if (row_hit) begin
                        st_d  = ST_CAS;
                        cnt_d = CNT_W'(T_CAS - 1);
                    end else if (row_open) begin
                        st_d      = ST_PRE;
                        cnt_d     = CNT_W'(T_RP - 1);
                        after_d   = AFTER_ACT;
                        close_row = 1'b1;
                    end else begin
                        st_d    = ST_ACT;
                        cnt_d   = CNT_W'(T_RCD - 1);
                        open_en = 1'b1;
                    end
                end
            end
            ST_ACT: if (cnt_q == '0) begin
                st_d  = ST_CAS;
                cnt_d = CNT_W'(T_CAS - 1);
            end
            ST_CAS: if (cnt_q == '0) begin
                st_d   = ST_IDLE;
                cap_rd = !req_q.we;
            end
            ST_PRE: if (cnt_q == '0) begin
                unique case (after_q)
                    AFTER_ACT: begin
                        st_d    = ST_ACT;
                        cnt_d   = CNT_W'(T_RCD - 1);
                        open_en = 1'b1;
                    end
                    AFTER_REF: begin
                        ref_ack = 1'b1;
                        st_d    = (ref_mode == REF_STYLE_CBR) ? ST_CBR_LEAD : ST_RREF;
                        cnt_d   = (ref_mode == REF_STYLE_CBR) ? '0 : CNT_W'(T_RAS - 1);
                    end
                    default: st_d = ST_IDLE;
                endcase
            end
            ST_RREF: if (cnt_q == '0) begin
                st_d        = ST_PRE;
                cnt_d       = CNT_W'(T_RP - 1);
                after_d     = AFTER_IDLE;
                ref_row_inc = 1'b1;
            end
            ST_CBR_LEAD: begin
                st_d  = ST_CBR_HOLD;
                cnt_d = CNT_W'(T_RAS - 1);
            end
            ST_CBR_HOLD: if (cnt_q == '0) begin
                st_d    = ST_PRE;
                cnt_d   = CNT_W'(T_RP - 1);
                after_d = AFTER_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            after_q   <= AFTER_IDLE;
            cnt_q     <= '0;
            req_q     <= '0;
            ref_row_q <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            st_q      <= st_d;
            after_q   <= after_d;
            cnt_q     <= cnt_d;
            rsp_valid <= cap_rd;
            if (accept)
                req_q <= '{row: in_row, col: req_addr[COL_W-1:0], we: req_we, wdata: req_wdata};
            if (ref_row_inc)
                ref_row_q <= ref_row_q + 1'b1;
            if (cap_rd)
                rsp_rdata <= dram_dq_in;
        end
    end

    always_comb begin
        dram_ras_n  = 1'b1;
        dram_cas_n  = 1'b1;
        dram_we_n   = 1'b1;
        dram_dq_oe  = 1'b0;
        dram_addr   = '0;
        dram_dq_out = req_q.wdata;
        unique case (st_q)
            ST_IDLE:     dram_ras_n = !row_open;
            ST_ACT: begin
                dram_ras_n = 1'b0;
                dram_addr  = PIN_W'(req_q.row);
            end
            ST_CAS: begin
                dram_ras_n = 1'b0;
                dram_cas_n = 1'b0;
                dram_addr  = PIN_W'(req_q.col);
                dram_we_n  = !req_q.we;
                dram_dq_oe = req_q.we;
            end
            ST_RREF: begin
                dram_ras_n = 1'b0;
                dram_addr  = PIN_W'(ref_row_q);
            end
            ST_CBR_LEAD: dram_cas_n = 1'b0;
            ST_CBR_HOLD: begin
                dram_ras_n = 1'b0;
                dram_cas_n = 1'b0;
            end
            default: ;
        endcase
    end

    // R2: data is driven only inside a column pulse of an open row
    assert_dq_in_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        dram_dq_oe |-> (!dram_cas_n && !dram_ras_n && !dram_we_n));

    // R1: a host column pulse starts only on a row already strobed
    assert_row_before_col_R1: assert property (@(posedge clk) disable iff (rst)
        ($fell(dram_cas_n) && !dram_ras_n) |-> $past(!dram_ras_n));

    // R5, R9: a rising row strobe is followed by at least one more high cycle
    assert_precharge_min_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(dram_ras_n) |=> dram_ras_n);

    // R8: column-first refresh keeps the column strobe low as the row strobe falls
    assert_cbr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (dram_ras_n && !dram_cas_n) |=> !dram_cas_n);

    // R3: read data appears only right after a column pulse
    assert_rsp_after_cas_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!dram_cas_n));

    // R6: no host request is taken while refresh is owed
    assert_ready_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        ref_pend |-> !req_ready);

endmodule

// File: tb/dramc_ctrl_tb.sv
module dramc_ctrl_tb;
    localparam int ROW_W = 3;
    localparam int COL_W = 3;
    localparam int DATA_W = 8;
    localparam int T_RCD = 2;
    localparam int T_CAS = 2;
    localparam int T_RP = 3;
    localparam int REF_INTERVAL = 100;
    localparam int WORDS = 1 << (ROW_W + COL_W);
    localparam int ROWS = 1 << ROW_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [ROW_W+COL_W-1:0] req_addr = '0;
    logic req_we = 1'b0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic ref_mode = 1'b0;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
    logic [2:0] dram_addr;
    logic [DATA_W-1:0] dram_dq_out, dram_dq_in;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dramc_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .REF_INTERVAL(REF_INTERVAL)
    ) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_mode(ref_mode),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    // ---------------- DRAM model ----------------
    logic [DATA_W-1:0] mem [WORDS];
    logic [ROW_W-1:0] mrow = '0;
    logic prev_ras = 1'b1, prev_cas = 1'b1;
    bit cas_seen = 0, cbr_flag = 0;
    int cyc = 0, fall_cyc = 0, rise_cyc = -100, cas_fall_cyc = 0;
    int last_ref_fall = -1, ref_gap = 0, pend_ref_fall = 0;
    int ror_cnt = 0, cbr_cnt = 0, host_opens = 0;
    int min_rp = 1000, min_rcd = 1000, cas_w_err = 0, we_err = 0, ror_seq_err = 0;
    logic [ROW_W-1:0] exp_ror = '0;

    assign dram_dq_in = (!dram_ras_n && !dram_cas_n && dram_we_n) ? mem[{mrow, dram_addr}] : '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (!dram_ras_n && !dram_cas_n && !dram_we_n) begin
                if (dram_dq_oe) mem[{mrow, dram_addr}] <= dram_dq_out;
                else we_err <= we_err + 1;
            end
            if (prev_ras && !dram_ras_n) begin
                if (cyc - rise_cyc < min_rp) min_rp <= cyc - rise_cyc;
                fall_cyc <= cyc;
                cas_seen <= 0;
                if (!dram_cas_n) begin
                    cbr_flag <= 1;
                    cbr_cnt <= cbr_cnt + 1;
                    if (last_ref_fall >= 0) ref_gap <= cyc - last_ref_fall;
                    last_ref_fall <= cyc;
                end else begin
                    cbr_flag <= 0;
                    mrow <= dram_addr;
                end
            end
            if (!prev_ras && dram_ras_n) begin
                rise_cyc <= cyc;
                if (!cas_seen && !cbr_flag) begin
                    ror_cnt <= ror_cnt + 1;
                    if (mrow != exp_ror) ror_seq_err <= ror_seq_err + 1;
                    exp_ror <= mrow + 1'b1;
                    if (last_ref_fall >= 0) ref_gap <= fall_cyc - last_ref_fall;
                    last_ref_fall <= fall_cyc;
                end
            end
            if (prev_cas && !dram_cas_n && !dram_ras_n) begin
                if (!cas_seen) begin
                    host_opens <= host_opens + 1;
                    if (cyc - fall_cyc < min_rcd) min_rcd <= cyc - fall_cyc;
                end
                cas_seen <= 1;
                cas_fall_cyc <= cyc;
            end
            if (!prev_cas && dram_cas_n && !dram_ras_n && (cyc - cas_fall_cyc != T_CAS))
                cas_w_err <= cas_w_err + 1;
        end
        prev_ras <= dram_ras_n;
        prev_cas <= dram_cas_n;
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_ge(input string req, input longint act, input longint lo);
        checks++;
        if (act < lo) begin
            errors++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lo);
        end
    endtask

    task automatic issue(input int a, input bit we, input logic [DATA_W-1:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = (ROW_W + COL_W)'(a);
        req_we    = we;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_read(input int a, output logic [DATA_W-1:0] d);
        issue(a, 1'b0, '0);
        for (int k = 0; k < 200 && !rsp_valid; k++) @(negedge clk);
        d = rsp_rdata;
    endtask

    function automatic logic [DATA_W-1:0] pat1(input int a);
        return DATA_W'(a * 37 + 11);
    endfunction

    function automatic logic [DATA_W-1:0] pat2(input int a);
        return DATA_W'(a) ^ 8'hA5;
    endfunction

    initial begin
        for (int i = 0; i < WORDS; i++) mem[i] = '0;
    end

    initial begin
        int refs0, opens0, bad, c0, r0;
        logic [DATA_W-1:0] d;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 ras_n", dram_ras_n, 1);
        check("R10 cas_n", dram_cas_n, 1);
        check("R10 req_ready", req_ready, 1);
        check("R10 rsp_valid", rsp_valid, 0);

        // R4: sequential write sweep, page hits within each row
        refs0 = ror_cnt + cbr_cnt;
        opens0 = host_opens;
        for (int a = 0; a < WORDS; a++) issue(a, 1'b1, pat1(a));
        repeat (T_CAS + 2) @(negedge clk);
        check_ge("R4 row opens at least one per row", host_opens - opens0, ROWS);
        check_ge("R4 page mode reuse (bound minus opens)",
                 ROWS + (ror_cnt + cbr_cnt - refs0) - (host_opens - opens0), 0);

        // R1 R3 R5: stride-9 read sweep, every access misses the row
        bad = 0;
        for (int i = 0; i < WORDS; i++) begin
            int a = (i * 9) % WORDS;
            do_read(a, d);
            checks++;
            if (d !== pat1(a)) begin
                errors++; bad++;
                $display("FAIL R3 read addr %0d actual=%0d expected=%0d", a, d, pat1(a));
            end
        end
        check("R1 stride sweep mismatches", bad, 0);
        check_ge("R5 precharge gap", min_rp, T_RP);
        check_ge("R1 row-to-column delay", min_rcd, T_RCD);

        // R8: traffic under column-first refresh
        ref_mode = 1'b1;
        for (int a = 0; a < WORDS; a++) issue(a, 1'b1, pat2(a));
        bad = 0;
        for (int a = 0; a < WORDS; a++) begin
            do_read(a, d);
            checks++;
            if (d !== pat2(a)) begin
                errors++; bad++;
                $display("FAIL R8 read addr %0d actual=%0d expected=%0d", a, d, pat2(a));
            end
        end
        check("R2 write strobe without data drive", we_err, 0);
        check("R2 column pulse width errors", cas_w_err, 0);
        check_ge("R9 precharge before refresh", min_rp, T_RP);

        // R8: idle in column-first style
        c0 = cbr_cnt;
        r0 = ror_cnt;
        repeat (5 * REF_INTERVAL + 10) @(negedge clk);
        check_ge("R8 column-first refreshes", cbr_cnt - c0, 4);
        check("R8 no row-only refresh", ror_cnt - r0, 0);
        check("R6 idle refresh spacing (cbr)", ref_gap, REF_INTERVAL);

        // R7: idle in row-only style, full row sweep
        ref_mode = 1'b0;
        r0 = ror_cnt;
        repeat (10 * REF_INTERVAL + 10) @(negedge clk);
        check_ge("R7 row-only refreshes cover rows", ror_cnt - r0, ROWS);
        check("R7 row counter sequence errors", ror_seq_err, 0);
        check("R6 idle refresh spacing (row-only)", ref_gap, REF_INTERVAL);
        check("R3 no response while idle", rsp_valid, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule